// File: doc/BRIEF.md
# Step Attenuator Control Driver

This block is the digital control front end of a seven-bit RF step attenuator. It takes the slow external control pins (a mode select, a serial clock, serial data, a latch strobe and seven parallel code lines), samples them with a fast internal system clock, and drives a registered seven-bit code to the attenuator stages. Bit i of the code switches in a stage of 0.25 dB times 2^i. The total attenuation is the sum of the enabled stages, from 0 dB up to 31.75 dB when all bits are set.

Two front ends feed one output register. The serial front end shifts a word in on serial clock rising edges and commits it on a strobe pulse. The parallel front end is transparent while the strobe is high and holds its value while the strobe is low. After reset the output is forced to maximum attenuation. It stays there for a programmable settling interval before any input is accepted.

Top module: `step_atten_ctrl`

## Requirements
- R1: After reset, atten_o is 7'h7F (maximum attenuation) and stays 7'h7F, whatever the inputs do, until PWRUP_CYCLES system clocks after reset release.
- R2: mode_i high selects the serial front end and mode_i low selects the parallel front end. In serial mode pdata_i has no effect on atten_o, and in parallel mode the serial pins and the shift register contents have no effect on atten_o.
- R3: In serial mode, with the strobe low, each rising edge of sclk_i shifts sdata_i into a seven-bit register at bit 0, moving older bits toward bit 6. The first of seven bits therefore lands in bit 6 and the last in bit 0.
- R4: While the strobe is high, serial clock edges do not change the shift register.
- R5: In serial mode, a rising edge of the strobe copies the shift register to atten_o. No other serial activity changes atten_o.
- R6: In parallel mode with the strobe high, atten_o follows pdata_i bit for bit (atten_o[i] = pdata_i[i], bit 6 weighing 16 dB and bit 0 0.25 dB).
- R7: In parallel mode with the strobe low, atten_o holds the value it had when the strobe fell, and pdata_i changes are ignored.
- R8: Switching mode_i while the strobe is low does not change atten_o.
- R9: Every pin passes through a two-flop synchroniser. A change on pdata_i in transparent parallel mode shows on atten_o after the third rising system clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Front end select: 1 serial, 0 parallel |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| latch_i | input | 1 | Latch strobe pin, asynchronous |
| pdata_i | input | 7 | Parallel code pins, asynchronous |
| atten_o | output | 7 | Registered attenuation code to the stages |

## Verification
The hardest case to reach is the masked serial clock. A shift that should have been blocked leaves atten_o unchanged until a later commit, so it is invisible when it happens. The bench therefore commits a known word, toggles the serial clock with the complementary data while the strobe stays high, and then pulses the strobe again. The output must still show the first word. A second subtle case is a mode switch with the strobe low, after different data has been presented to the other front end. This exposes any path that lets the inactive front end reach the output.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned CODE_W = 7;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_MAX = '1;
endpackage

// File: rtl/atten_pin_sync.sv
module atten_pin_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  serial_mode,
  input  logic  strobe,
  input  logic  sclk,
  input  logic  sdata,
  output code_t word_o
);
  logic  sclk_prev;
  logic  sclk_rise;
  code_t word_q;

  assign sclk_rise = sclk & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      word_q    <= '0;
    end else begin
      sclk_prev <= sclk;
      if (serial_mode && !strobe && sclk_rise)
        word_q <= {word_q[CODE_W-2:0], sdata};
    end
  end

  assign word_o = word_q;

  // R4: a high strobe masks every serial clock edge
  assert_shift_masked_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |=> $stable(word_q));
  // R2: the shift register is idle in parallel mode
  assert_shift_idle_par_R2: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> $stable(word_q));
endmodule

// File: rtl/atten_out_latch.sv
module atten_out_latch
  import atten_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 256
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  serial_mode,
  input  logic  strobe,
  input  code_t shift_word,
  input  code_t par_word,
  output code_t atten_o
);
  localparam int unsigned CNT_W = $clog2(PWRUP_CYCLES + 1);

  logic [CNT_W-1:0] wait_cnt;
  logic             ready;
  logic             strobe_prev;
  logic             strobe_rise;
  code_t            atten_q;

  assign ready       = (wait_cnt == CNT_W'(PWRUP_CYCLES));
  assign strobe_rise = strobe & ~strobe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt    <= '0;
      strobe_prev <= 1'b0;
      atten_q     <= CODE_MAX;
    end else begin
      strobe_prev <= strobe;
      if (!ready) begin
        wait_cnt <= wait_cnt + 1'b1;
      end else if (serial_mode) begin
        if (strobe_rise) atten_q <= shift_word;
      end else if (strobe) begin
        atten_q <= par_word;
      end
    end
  end

  assign atten_o = atten_q;

  // R1: maximum attenuation until the settling interval ends
  assert_pwrup_max_R1: assert property (@(posedge clk) disable iff (rst)
    !ready |-> atten_q == CODE_MAX);
  // R5: in serial mode only a strobe rise moves the output
  assert_serial_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && !strobe_rise) |=> $stable(atten_q));
  // R5: a strobe rise in serial mode commits the shift word
  assert_serial_load_R5: assert property (@(posedge clk) disable iff (rst)
    (ready && serial_mode && strobe_rise) |=> atten_q == $past(shift_word));
  // R6: transparent parallel operation
  assert_transparent_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && !serial_mode && strobe) |=> atten_q == $past(par_word));
  // R7: strobe low freezes the parallel value
  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!serial_mode && !strobe) |=> $stable(atten_q));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 256,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_i,
  input  logic [CODE_W-1:0] pdata_i,
  output logic [CODE_W-1:0] atten_o
);
  localparam int unsigned PIN_W = CODE_W + 4;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             mode_s, sclk_s, sdata_s, latch_s;
  code_t            pdata_s;
  code_t            shift_word;

  assign pins_raw = {mode_i, sclk_i, sdata_i, latch_i, pdata_i};
  assign {mode_s, sclk_s, sdata_s, latch_s, pdata_s} = pins_s;

  atten_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  atten_shift_reg u_shift (
    .clk         (clk),
    .rst         (rst),
    .serial_mode (mode_s),
    .strobe      (latch_s),
    .sclk        (sclk_s),
    .sdata       (sdata_s),
    .word_o      (shift_word)
  );

  atten_out_latch #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .serial_mode (mode_s),
    .strobe      (latch_s),
    .shift_word  (shift_word),
    .par_word    (pdata_s),
    .atten_o     (atten_o)
  );

  // R8: a mode switch with the strobe low leaves the output alone
  assert_mode_switch_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_s != $past(mode_s) && !latch_s && !$past(latch_s)) |=> $stable(atten_o));
endmodule

// File: tb/step_atten_ctrl_bench.sv
`timescale 1ns/1ps
module step_atten_ctrl_bench;
  localparam int PWRUP = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0, latch_i = 1'b0;
  logic [6:0] pdata_i = '0;
  logic [6:0] atten_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  step_atten_ctrl #(.PWRUP_CYCLES(PWRUP)) u_step_atten_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .latch_i(latch_i), .pdata_i(pdata_i), .atten_o(atten_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    total++;
    if (atten_o !== exp) begin
      bad++;
      $display("FAIL %s: atten_o=%h expected=%h", req, atten_o, exp);
    end
  endtask

  task automatic pulse_sclk(input logic b);
    sdata_i = b; cyc(4);
    sclk_i = 1'b1; cyc(4);
    sclk_i = 1'b0; cyc(4);
  endtask

  task automatic shift_word(input logic [6:0] w);
    for (int i = 6; i >= 0; i--) pulse_sclk(w[i]);
  endtask

  task automatic pulse_latch;
    latch_i = 1'b1; cyc(5);
    latch_i = 1'b0; cyc(5);
  endtask

  task automatic t_reset;
    cyc(3); rst = 1'b0;
    chk("R1 reset", 7'h7F);
    latch_i = 1'b1; pdata_i = 7'h00;
    cyc(12);
    chk("R1 hold during settling", 7'h7F);
    cyc(PWRUP);
    chk("R6 after settling", 7'h00);
  endtask

  task automatic t_direct;
    latch_i = 1'b1;
    pdata_i = 7'h55; cyc(5); chk("R6 pattern 55", 7'h55);
    pdata_i = 7'h2A; cyc(5); chk("R6 pattern 2A", 7'h2A);
    pdata_i = 7'h01; cyc(5); chk("R6 lsb only", 7'h01);
    pdata_i = 7'h40; cyc(2); chk("R9 not yet after two edges", 7'h01);
    cyc(1); chk("R9 visible after third edge", 7'h40);
  endtask

  task automatic t_latched;
    pdata_i = 7'h33; cyc(5);
    latch_i = 1'b0; cyc(5);
    pdata_i = 7'h0C; cyc(6); chk("R7 frozen with strobe low", 7'h33);
    pulse_latch; chk("R7 strobe pulse passes new code", 7'h0C);
    pdata_i = 7'h7E; cyc(6); chk("R7 frozen after pulse", 7'h0C);
  endtask

  task automatic t_serial;
    mode_i = 1'b1; cyc(5);
    shift_word(7'b1010011);
    chk("R5 no change before strobe", 7'h0C);
    pulse_latch; chk("R3 serial word committed", 7'b1010011);
    shift_word(7'b1000000);
    pulse_latch; chk("R3 first bit lands in msb", 7'b1000000);
    pdata_i = 7'h11; latch_i = 1'b1; cyc(6);
    chk("R2 pdata ignored in serial mode", 7'b1000000);
    latch_i = 1'b0; cyc(5);
  endtask

  task automatic t_mask;
    shift_word(7'b0110101);
    latch_i = 1'b1; cyc(5);
    chk("R5 commit before mask test", 7'b0110101);
    for (int i = 6; i >= 0; i--) pulse_sclk(~7'b0110101 >> i);
    latch_i = 1'b0; cyc(5);
    pulse_latch; chk("R4 masked edges left shift reg", 7'b0110101);
  endtask

  task automatic t_mode;
    pdata_i = 7'h22; cyc(5);
    mode_i = 1'b0; cyc(6);
    chk("R8 serial to parallel strobe low", 7'b0110101);
    shift_word(7'h7F);
    chk("R2 serial pins ignored in parallel mode", 7'b0110101);
    mode_i = 1'b1; cyc(6);
    chk("R8 parallel to serial strobe low", 7'b0110101);
    mode_i = 1'b0; cyc(5);
    pulse_latch; chk("R2 parallel strobe takes pdata", 7'h22);
  endtask

  initial begin
    t_reset;
    t_direct;
    t_latched;
    t_serial;
    t_mask;
    t_mode;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule